// File: doc/BRIEF.md
# Single-Line Resistor Keypad Decoder

This block turns the readings of one analog input into keypad events. A resistor ladder is wired to that input. Each of up to ten push buttons pulls the line to its own voltage band, and the line rests near full scale when no button is down. An external converter delivers 12-bit samples with a valid strobe. A 1 ms tick paces the processing.

On every tick the most recently latched sample is matched against a set of ascending threshold words, which gives a key code, an idle code or an unclassified result. The result is debounced over a run of identical ticks. A small press tracker then measures how long the key is held. When a held key is released, the tracker reports a short press. When the hold time reaches the long limit, it reports one long press at that moment. Only one key is recognised at a time. Moving from one key to another without passing through idle abandons the press, and no event is reported for it.

Top module: `keypad_ladder_dec`

## Requirements
- R1: With thresholds thr[0] < thr[1] < ... < thr[NUM_KEYS], a sample s where thr[k] <= s < thr[k+1] decodes as key k (0..NUM_KEYS-1). A sample s >= thr[NUM_KEYS] decodes as idle. A sample below thr[0] is unclassified.
- R2: A sample is latched on a cycle with smp_valid_i high. Decoding happens only on cycles with tick_i high. Events appear as one-cycle pulses in the cycle after the tick that caused them.
- R3: A key is accepted as pressed only after DEB_CNT consecutive ticks decode to that same key. A shorter run is discarded.
- R4: A release is accepted after DEB_CNT consecutive idle ticks. If this happens before the long limit is reached, a short event carrying the key code is reported.
- R5: A long event is reported exactly once, on the LONG_MS-th tick after the tick that accepted the press. The release that follows reports nothing.
- R6: If the accepted release falls on that same LONG_MS-th tick, the event is long and no short event is reported.
- R7: If a different key is accepted while a press is in progress, that press is cancelled. No event is reported for it or for the new key, and reporting resumes only after idle has been accepted.
- R8: Unclassified ticks restart the debounce run. They neither release a held key nor press a new one.
- R9: evt_valid_o is high exactly when one of short_o and long_o is high, and key_o then holds a key code below NUM_KEYS.
- R10: After reset all event outputs are low and the decoder is in the idle, released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | SAMPLE_W (12) | Converter sample |
| smp_valid_i | input | 1 | Sample strobe, latches smp_i |
| tick_i | input | 1 | 1 ms processing strobe |
| thr_i | input | (NUM_KEYS+1)*SAMPLE_W (132) | Ascending window thresholds; entry NUM_KEYS starts the idle band |
| evt_valid_o | output | 1 | Event pulse |
| short_o | output | 1 | Event is a short press |
| long_o | output | 1 | Event is a long press |
| key_o | output | CODE_W (4) | Key code of the event |

## Verification
The accepted release and the long-limit expiry can fall on the same tick. This is the one case where two events compete for the single output pulse. The bench provokes it by timing the idle run so that its final debounce tick lands exactly on the LONG_MS-th tick after acceptance, and the result is judged as a long event only. One tick earlier the same press must give a short event.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_HELD   = 2'd1,
    PS_LONG   = 2'd2,
    PS_CANCEL = 2'd3
  } press_st_e;
endpackage

// File: rtl/kpd_window_cls.sv
module kpd_window_cls #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = 4
) (
  input  logic [SAMPLE_W-1:0]               smp_i,
  input  logic [NUM_KEYS:0][SAMPLE_W-1:0]   thr_i,
  output logic [CODE_W-1:0]                 code_o
);
  localparam logic [CODE_W-1:0] CODE_IDLE = CODE_W'(NUM_KEYS);
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  // ascending thresholds: highest matched lower bound wins
  always_comb begin
    code_o = CODE_NONE;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (smp_i >= thr_i[k]) code_o = CODE_W'(k);
    end
    if (smp_i >= thr_i[NUM_KEYS]) code_o = CODE_IDLE;
  end
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce #(
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = 4,
  parameter int DEB_CNT  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              acc_o,
  output logic [CODE_W-1:0] acc_code_o
);
  localparam int CNT_W = $clog2(DEB_CNT + 1);
  localparam logic [CODE_W-1:0] CODE_IDLE = CODE_W'(NUM_KEYS);
  localparam logic [CODE_W-1:0] CODE_NONE = '1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(DEB_CNT - 1);
  localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(DEB_CNT);

  logic [CODE_W-1:0] cand_q, deb_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              same;

  assign same       = (code_i == cand_q);
  assign acc_o      = tick_i && same && (cnt_q == CNT_LAST) &&
                      (cand_q != deb_q) && (cand_q != CODE_NONE);
  assign acc_code_o = cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= CODE_IDLE;
      deb_q  <= CODE_IDLE;
      cnt_q  <= CNT_SAT;
    end else if (tick_i) begin
      if (!same) begin
        cand_q <= code_i;
        cnt_q  <= CNT_W'(1);
      end else if (cnt_q != CNT_SAT) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (acc_o) deb_q <= cand_q;
    end
  end
endmodule

// File: rtl/kpd_press_fsm.sv
module kpd_press_fsm
  import kpd_pkg::*;
#(
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = 4,
  parameter int LONG_MS  = 800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              acc_i,
  input  logic [CODE_W-1:0] acc_code_i,
  output logic              evt_valid_o,
  output logic              short_o,
  output logic              long_o,
  output logic [CODE_W-1:0] key_o
);
  localparam int HOLD_W = $clog2(LONG_MS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(LONG_MS - 1);
  localparam logic [CODE_W-1:0] CODE_IDLE = CODE_W'(NUM_KEYS);

  press_st_e         st_q, st_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [CODE_W-1:0] key_q, key_d;
  logic              sh_d, lg_d;
  logic              acc_idle, acc_key;

  assign acc_idle = acc_i && (acc_code_i == CODE_IDLE);
  assign acc_key  = acc_i && (acc_code_i < CODE_IDLE);

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    key_d  = key_q;
    sh_d   = 1'b0;
    lg_d   = 1'b0;
    unique case (st_q)
      PS_IDLE: if (acc_key) begin
        st_d   = PS_HELD;
        key_d  = acc_code_i;
        hold_d = '0;
      end
      PS_HELD: if (tick_i) begin
        if (hold_q == HOLD_LAST) begin
          // limit reached: long wins over a coinciding release
          lg_d = 1'b1;
          st_d = acc_idle ? PS_IDLE : (acc_key ? PS_CANCEL : PS_LONG);
        end else if (acc_idle) begin
          sh_d = 1'b1;
          st_d = PS_IDLE;
        end else if (acc_key) begin
          st_d = PS_CANCEL;
        end else begin
          hold_d = hold_q + HOLD_W'(1);
        end
      end
      PS_LONG: begin
        if (acc_idle)     st_d = PS_IDLE;
        else if (acc_key) st_d = PS_CANCEL;
      end
      PS_CANCEL: if (acc_idle) st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PS_IDLE;
      hold_q      <= '0;
      key_q       <= '0;
      evt_valid_o <= 1'b0;
      short_o     <= 1'b0;
      long_o      <= 1'b0;
      key_o       <= '0;
    end else begin
      st_q        <= st_d;
      hold_q      <= hold_d;
      key_q       <= key_d;
      evt_valid_o <= sh_d | lg_d;
      short_o     <= sh_d;
      long_o      <= lg_d;
      if (sh_d | lg_d) key_o <= key_q;
    end
  end
endmodule

// File: rtl/keypad_ladder_dec.sv
module keypad_ladder_dec #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_KEYS = 10,
  parameter int DEB_CNT  = 20,
  parameter int LONG_MS  = 800,
  parameter int CODE_W   = $clog2(NUM_KEYS + 2)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SAMPLE_W-1:0]              smp_i,
  input  logic                             smp_valid_i,
  input  logic                             tick_i,
  input  logic [NUM_KEYS:0][SAMPLE_W-1:0]  thr_i,
  output logic                             evt_valid_o,
  output logic                             short_o,
  output logic                             long_o,
  output logic [CODE_W-1:0]                key_o
);
  logic [SAMPLE_W-1:0] smp_q;
  logic [CODE_W-1:0]   code, acc_code;
  logic                acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          smp_q <= '1;
    else if (smp_valid_i) smp_q <= smp_i;
  end

  kpd_window_cls #(.SAMPLE_W(SAMPLE_W), .NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_cls (
    .smp_i  (smp_q),
    .thr_i  (thr_i),
    .code_o (code)
  );

  kpd_debounce #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W), .DEB_CNT(DEB_CNT)) u_deb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .code_i     (code),
    .acc_o      (acc),
    .acc_code_o (acc_code)
  );

  kpd_press_fsm #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W), .LONG_MS(LONG_MS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .acc_i       (acc),
    .acc_code_i  (acc_code),
    .evt_valid_o (evt_valid_o),
    .short_o     (short_o),
    .long_o      (long_o),
    .key_o       (key_o)
  );
endmodule

// File: rtl/kpd_checker.sv
module kpd_checker #(
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              evt_valid_o,
  input logic              short_o,
  input logic              long_o,
  input logic [CODE_W-1:0] key_o
);
  a_r9_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> $onehot({short_o, long_o}));

  a_r9_flags_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_o |-> !short_o && !long_o);

  a_r9_key_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (key_o < CODE_W'(NUM_KEYS)));

  a_r2_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_valid_o) |-> $past(tick_i));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);
endmodule

bind keypad_ladder_dec kpd_checker #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .evt_valid_o (evt_valid_o),
  .short_o     (short_o),
  .long_o      (long_o),
  .key_o       (key_o)
);

// File: tb/keypad_ladder_dec_tb.sv
module keypad_ladder_dec_tb_top;
  localparam int W  = 12;
  localparam int NK = 10;
  localparam int DB = 3;
  localparam int LM = 10;
  localparam int CW = 4;
  localparam logic [W-1:0] S_IDLE = 12'd4000;
  localparam logic [W-1:0] S_NONE = 12'd100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] smp_i = '1;
  logic smp_valid_i = 1'b0;
  logic tick_i = 1'b0;
  logic [NK:0][W-1:0] thr_i;
  logic evt_valid_o, short_o, long_o;
  logic [CW-1:0] key_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  function automatic logic [W-1:0] thr(input int k);
    return W'(200 + 300 * k);
  endfunction

  always_comb for (int k = 0; k <= NK; k++) thr_i[k] = thr(k);

  keypad_ladder_dec #(.SAMPLE_W(W), .NUM_KEYS(NK), .DEB_CNT(DB), .LONG_MS(LM)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .smp_valid_i(smp_valid_i),
    .tick_i(tick_i), .thr_i(thr_i), .evt_valid_o(evt_valid_o), .short_o(short_o),
    .long_o(long_o), .key_o(key_o));

  task automatic chk(input bit ev, input bit sh, input bit lg, input int k, input string tag);
    vectors++;
    if (evt_valid_o !== ev || short_o !== sh || long_o !== lg || (ev && key_o !== CW'(k))) begin
      fails++;
      $display("FAIL %s: got ev=%0b sh=%0b lg=%0b key=%0d, exp ev=%0b sh=%0b lg=%0b key=%0d",
               tag, evt_valid_o, short_o, long_o, key_o, ev, sh, lg, k);
    end
  endtask

  // one ms step: latch sample, tick, check result and pulse width (R2)
  task automatic step(input logic [W-1:0] s, input bit ev, input bit sh, input bit lg,
                      input int k, input string tag);
    @(negedge clk_i); smp_i = s; smp_valid_i = 1'b1;
    @(negedge clk_i); smp_valid_i = 1'b0; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    chk(ev, sh, lg, k, tag);
    @(negedge clk_i);
    chk(1'b0, 1'b0, 1'b0, 0, "R2 pulse width");
  endtask

  task automatic quiet(input logic [W-1:0] s, input int n, input string tag);
    for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got no finish, exp finish before %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(1'b0, 1'b0, 1'b0, 0, "R10 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1'b0, 1'b0, 1'b0, 0, "R10 after reset");

    // R1/R4: sweep all windows at both edges, short press each
    for (int k = 0; k < NK; k++) begin
      step(thr(k), 0, 0, 0, 0, "R1 low edge");
      step(thr(k + 1) - W'(1), 0, 0, 0, 0, "R1 high edge");
      step(thr(k) + W'(150), 0, 0, 0, 0, "R3 accept");
      quiet(S_IDLE, 2, "R4 release pending");
      step(thr(NK), 1, 1, 0, k, "R1 R4 short on idle boundary");
    end

    // R3: short run discarded, restart after interruption
    quiet(thr(2), 2, "R3 short run");
    quiet(S_IDLE, 3, "R3 discarded");
    quiet(thr(2), 3, "R3 accepted");
    quiet(S_IDLE, 2, "R3 idle run");
    quiet(thr(2), 1, "R3 bounce");
    quiet(S_IDLE, 2, "R3 idle rerun");
    step(S_IDLE, 1, 1, 0, 2, "R4 short after bounce");

    // R5: long fires once at LONG_MS-th tick, silent release
    quiet(thr(5), 3, "R5 accept");
    quiet(thr(5), LM - 1, "R5 holding");
    step(thr(5), 1, 0, 1, 5, "R5 long");
    quiet(thr(5), 3, "R5 still held");
    quiet(S_IDLE, 4, "R5 silent release");
    quiet(thr(6), 3, "R5 next press");
    quiet(S_IDLE, 2, "R5 next release");
    step(S_IDLE, 1, 1, 0, 6, "R5 back to idle");

    // R6: release one tick before the limit, then on it
    quiet(thr(7), 3, "R6 accept");
    quiet(thr(7), LM - 4, "R6 hold");
    quiet(S_IDLE, 2, "R6 release");
    step(S_IDLE, 1, 1, 0, 7, "R6 short before limit");
    quiet(thr(7), 3, "R6 accept2");
    quiet(thr(7), LM - 3, "R6 hold2");
    quiet(S_IDLE, 2, "R6 release2");
    step(S_IDLE, 1, 0, 1, 7, "R6 long on coincidence");
    quiet(S_IDLE, 3, "R6 no short");
    quiet(thr(8), 3, "R6 next press");
    quiet(S_IDLE, 2, "R6 next release");
    step(S_IDLE, 1, 1, 0, 8, "R6 idle state");

    // R7: key change cancels
    quiet(thr(1), 3, "R7 first key");
    quiet(thr(4), 5, "R7 second key");
    quiet(S_IDLE, 3, "R7 cancelled release");
    quiet(thr(0), 3, "R7 fresh press");
    quiet(S_IDLE, 2, "R7 fresh release");
    step(S_IDLE, 1, 1, 0, 0, "R7 reporting resumed");

    // R8: unclassified ticks neither press nor release
    quiet(S_NONE, 4, "R8 none from idle");
    quiet(thr(3), 3, "R8 accept");
    quiet(S_NONE, 2, "R8 none while held");
    quiet(thr(3), 1, "R8 key again");
    quiet(S_IDLE, 2, "R8 release");
    step(S_IDLE, 1, 1, 0, 3, "R8 short kept key");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule